// File: doc/BRIEF.md
# DMA Request Line Router

This block sits between a large set of peripheral DMA request lines and a bank of DMA channels. Each request line owns an 8-bit map entry that either leaves it unmapped or routes it to one channel. The router synchronizes the request lines and works out each channel's routed request level. It then emits single-cycle events when that level rises or falls. A status block consumes the rising event as "request arrived after stop" and as a kick to start the channel engine. It consumes the falling event as "end of receive", which also clears the request-after-stop flag.

Software reaches the map entries through a small register port. The table is split over two non-contiguous address windows. The low window holds the first 64 entries and the high window holds the rest. Both windows address one shared table. A write that enables a mapping to a channel number the instance does not have is still stored, but it routes nothing and raises a sticky error flag.

Top module: `dma_req_router`

## Requirements
- R1: After reset every map entry reads 0 (unmapped), and chan_req_o, req_rise_o, req_fall_o and map_err_o are all 0.
- R2: A map entry stores all 8 written bits and reads them back unchanged. Bit 7 is the valid flag and bits 4:0 are the channel number. Read data appears on reg_rdata_o one clock after the read strobe and holds until the next read.
- R3: Entry k for k in 0..63 sits at byte address 0x100 + 4k. Entry k for k in 64..74 sits at byte address 0x1100 + 4(k-64). A read from any other address, including a non-word-aligned one, returns 0, and a write to such an address changes no entry.
- R4: A request line whose entry has bit 7 clear drives no channel and causes no event.
- R5: The channel level on chan_req_o follows the routed request line. It changes on the third rising clock edge after the input changes: two synchronizer stages plus one output register.
- R6: req_rise_o pulses for exactly the one cycle in which a channel's level changes from 0 to 1.
- R7: req_fall_o pulses for exactly the one cycle in which a channel's level changes from 1 to 0.
- R8: When several valid entries name the same channel, the highest-numbered such request line alone sets that channel's level.
- R9: A write of a valid entry whose channel number is at least NUM_CH sets map_err_o, which stays set until reset. The entry is still stored, and it routes to no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_REQ | Asynchronous peripheral request lines |
| reg_wr_i | input | 1 | Map register write strobe |
| reg_rd_i | input | 1 | Map register read strobe |
| reg_addr_i | input | ADDR_W | Byte address of the access |
| reg_wdata_i | input | 8 | Write data for a map entry |
| reg_rdata_o | output | 8 | Read data, one cycle after the read strobe |
| map_err_o | output | 1 | Sticky out-of-range channel error |
| chan_req_o | output | NUM_CH | Routed request level per channel |
| req_rise_o | output | NUM_CH | One-cycle rising event per channel |
| req_fall_o | output | NUM_CH | One-cycle falling event per channel |

## Verification
The bench builds the router with NUM_CH = 8 and keeps the default 75 request lines and both address windows. With only 8 channels, the 5-bit channel field can name channels 8 to 31 that do not exist. This makes the out-of-range error and its "stored but routes nothing" behaviour reachable. With the full request count, both windows are covered, including the last entry at the top of the high window. Random remapping among a handful of channels creates frequent shared mappings, so the priority of the highest-numbered request line is exercised against edge events.

// File: rtl/reqroute_pkg.sv
package reqroute_pkg;
  localparam int unsigned ENTRY_W = 8;
  localparam int unsigned CHSEL_W = 5;

  // bit 7 valid, bits 6:5 kept for readback, bits 4:0 channel
  typedef struct packed {
    logic                 valid;
    logic [1:0]           spare;
    logic [CHSEL_W-1:0]   chan;
  } map_entry_t;
endpackage

// File: rtl/reqroute_sync.sv
module reqroute_sync #(
  parameter int unsigned WIDTH  = 75,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/reqroute_map_table.sv
module reqroute_map_table
  import reqroute_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 75,
  parameter int unsigned NUM_CH     = 32,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LO_ENTRIES = 64,
  parameter int unsigned LO_BASE    = 'h0100,
  parameter int unsigned HI_BASE    = 'h1100
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [ENTRY_W-1:0]         wdata_i,
  output logic [ENTRY_W-1:0]         rdata_o,
  output logic                       err_o,
  output logic [NUM_REQ-1:0]         vld_o,
  output logic [NUM_REQ-1:0][CHSEL_W-1:0] chan_o
);
  localparam int unsigned HI_ENTRIES = NUM_REQ - LO_ENTRIES;
  localparam int unsigned IDX_W      = $clog2(NUM_REQ);
  localparam logic [ADDR_W-1:0] LO_BASE_A = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_BASE_A = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] LO_SPAN   = ADDR_W'(LO_ENTRIES * 4);
  localparam logic [ADDR_W-1:0] HI_SPAN   = ADDR_W'(HI_ENTRIES * 4);

  map_entry_t        tbl_q [NUM_REQ];
  logic [ADDR_W-1:0] lo_off, hi_off;
  logic              lo_hit, hi_hit, hit;
  logic [IDX_W-1:0]  idx;
  logic              bad_chan;
  logic [ENTRY_W-1:0] rdata_q;
  logic              err_q;

  always_comb begin
    lo_off = addr_i - LO_BASE_A;
    hi_off = addr_i - HI_BASE_A;
    lo_hit = (addr_i >= LO_BASE_A) && (lo_off < LO_SPAN) && (addr_i[1:0] == 2'b00);
    hi_hit = (addr_i >= HI_BASE_A) && (hi_off < HI_SPAN) && (addr_i[1:0] == 2'b00);
    hit    = lo_hit | hi_hit;
    if (lo_hit) idx = lo_off[IDX_W+1:2];
    else        idx = IDX_W'(LO_ENTRIES) + hi_off[IDX_W+1:2];
  end

  // channel number outside the instance; CHSEL_W+1 bits so NUM_CH = 32 fits
  assign bad_chan = wdata_i[ENTRY_W-1] &&
                    ({1'b0, wdata_i[CHSEL_W-1:0]} >= (CHSEL_W+1)'(NUM_CH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REQ; r++) tbl_q[r] <= '0;
    end else if (wr_i && hit) begin
      tbl_q[idx] <= map_entry_t'(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= hit ? ENTRY_W'(tbl_q[idx]) : '0;
      if (wr_i && hit && bad_chan) err_q <= 1'b1;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_out
    assign vld_o[r]  = tbl_q[r].valid;
    assign chan_o[r] = tbl_q[r].chan;
  end
endmodule

// File: rtl/reqroute_chan_route.sv
module reqroute_chan_route
  import reqroute_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REQ-1:0]             req_s_i,
  input  logic [NUM_REQ-1:0]             vld_i,
  input  logic [NUM_REQ-1:0][CHSEL_W-1:0] chan_i,
  output logic [NUM_CH-1:0]              lvl_o,
  output logic [NUM_CH-1:0]              rise_o,
  output logic [NUM_CH-1:0]              fall_o
);
  logic [NUM_CH-1:0] lvl_d, lvl_q, rise_q, fall_q;

  // ascending scan: the last (highest-numbered) valid match wins
  always_comb begin
    lvl_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (vld_i[r] && (chan_i[r] == CHSEL_W'(c))) lvl_d[c] = req_s_i[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      rise_q <= lvl_d & ~lvl_q;
      fall_q <= ~lvl_d & lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import reqroute_pkg::*;
#(
  parameter int unsigned NUM_REQ     = 75,
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned LO_ENTRIES  = 64,
  parameter int unsigned LO_BASE     = 'h0100,
  parameter int unsigned HI_BASE     = 'h1100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic               map_err_o,
  output logic [NUM_CH-1:0]  chan_req_o,
  output logic [NUM_CH-1:0]  req_rise_o,
  output logic [NUM_CH-1:0]  req_fall_o
);
  logic [NUM_REQ-1:0]              req_s;
  logic [NUM_REQ-1:0]              map_vld;
  logic [NUM_REQ-1:0][CHSEL_W-1:0] map_chan;

  reqroute_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  reqroute_map_table #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
    .LO_ENTRIES(LO_ENTRIES), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_table (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .err_o  (map_err_o),
    .vld_o  (map_vld),
    .chan_o (map_chan)
  );

  reqroute_chan_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_s_i(req_s),
    .vld_i  (map_vld),
    .chan_i (map_chan),
    .lvl_o  (chan_req_o),
    .rise_o (req_rise_o),
    .fall_o (req_fall_o)
  );
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk #(
  parameter int unsigned NUM_CH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              map_err_o,
  input logic [NUM_CH-1:0] chan_req_o,
  input logic [NUM_CH-1:0] req_rise_o,
  input logic [NUM_CH-1:0] req_fall_o
);
  // R6
  rise_sets_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rise_o & ~chan_req_o) == '0);
  // R7
  fall_clears_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fall_o & chan_req_o) == '0);
  // R6
  rise_marks_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_req_o & ~$past(chan_req_o)) == req_rise_o);
  // R7
  fall_marks_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~chan_req_o & $past(chan_req_o)) == req_fall_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(map_err_o) |-> map_err_o);
endmodule

bind dma_req_router dma_req_router_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/tb_dma_req_router.sv
`timescale 1ns/1ps
module tb_dma_req_router;
  localparam int NREQ = 75;
  localparam int NCH  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NREQ-1:0] req = '0;
  logic            wr = 1'b0, rd = 1'b0;
  logic [15:0]     addr = '0;
  logic [7:0]      wdata = '0;
  logic [7:0]      rdata;
  logic            err;
  logic [NCH-1:0]  lvl, rise, fall;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_req_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .map_err_o(err),
    .chan_req_o(lvl), .req_rise_o(rise), .req_fall_o(fall)
  );

  // ---------------- reference model ----------------
  bit [7:0]      m_map [NREQ];
  bit [NREQ-1:0] m_s1, m_s2;
  bit [NCH-1:0]  m_lvl, m_rise, m_fall;
  bit            m_err;
  bit [7:0]      m_rdata;

  function automatic int decode(int a);
    if (a >= 'h100 && a < 'h100 + 64*4 && a % 4 == 0) return (a - 'h100) / 4;
    if (a >= 'h1100 && a < 'h1100 + (NREQ-64)*4 && a % 4 == 0) return 64 + (a - 'h1100) / 4;
    return -1;
  endfunction

  function automatic bit [NCH-1:0] route(bit [NREQ-1:0] s);
    bit [NCH-1:0] v = '0;
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < NREQ; r++)
        if (m_map[r][7] && int'(m_map[r][4:0]) == c) v[c] = s[r];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREQ; r++) m_map[r] = '0;
      m_s1 = '0; m_s2 = '0; m_lvl = '0; m_rise = '0; m_fall = '0;
      m_err = 0; m_rdata = '0;
    end else begin
      bit [NCH-1:0] nl;
      int k;
      nl = route(m_s2);
      m_rise = nl & ~m_lvl;
      m_fall = ~nl & m_lvl;
      m_lvl = nl;
      k = decode(int'(addr));
      if (rd) m_rdata = (k >= 0) ? m_map[k] : 8'h00;
      if (wr && k >= 0) begin
        m_map[k] = wdata;
        if (wdata[7] && int'(wdata[4:0]) >= NCH) m_err = 1;
      end
      m_s2 = m_s1;
      m_s1 = req;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(lvl == m_lvl,   "R5 level",     32'(lvl),   32'(m_lvl));
    chk(rise == m_rise, "R6 rise",      32'(rise),  32'(m_rise));
    chk(fall == m_fall, "R7 fall",      32'(fall),  32'(m_fall));
    chk(err == m_err,   "R9 err",       32'(err),   32'(m_err));
    chk(rdata == m_rdata, "R2 rdata",   32'(rdata), 32'(m_rdata));
  end

  task automatic wr_reg(int a, int d);
    @(negedge clk); wr = 1; addr = 16'(a); wdata = 8'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(int a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = 16'(a);
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 act=hung exp=done");
    summary();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(lvl == 0 && rise == 0 && fall == 0 && err == 0, "R1 outputs", 32'({err, lvl}), 0);
    rd_reg('h100, d);  chk(d == 0, "R1 entry0", 32'(d), 0);
    rd_reg('h1128, d); chk(d == 0, "R1 entry74", 32'(d), 0);
    // R2 all bits stored
    wr_reg('h10C, 'hE2); rd_reg('h10C, d); chk(d == 8'hE2, "R2 readback", 32'(d), 32'hE2);
    wr_reg('h10C, 'h82); rd_reg('h10C, d); chk(d == 8'h82, "R2 entry3", 32'(d), 32'h82);
    // R3 windows
    wr_reg('h1118, 'h85); rd_reg('h1118, d); chk(d == 8'h85, "R3 hi window", 32'(d), 32'h85);
    wr_reg('h1128, 'h81); rd_reg('h1128, d); chk(d == 8'h81, "R3 last entry", 32'(d), 32'h81);
    wr_reg('h102, 'h83); rd_reg('h100, d); chk(d == 0, "R3 misaligned", 32'(d), 0);
    rd_reg('h102, d); chk(d == 0, "R3 misaligned read", 32'(d), 0);
    wr_reg('h112C, 'h84); rd_reg('h112C, d); chk(d == 0, "R3 past window", 32'(d), 0);
    rd_reg('h200, d); chk(d == 0, "R3 gap", 32'(d), 0);
    // R5/R6 latency on request 3 -> channel 2
    @(negedge clk); req[3] = 1;
    @(negedge clk); @(negedge clk);
    chk(lvl[2] == 0, "R5 not before third edge", 32'(lvl), 0);
    @(negedge clk);
    chk(lvl[2] == 1 && rise[2] == 1, "R6 rise at third edge", 32'({rise, lvl}), 32'h0404);
    @(negedge clk);
    chk(rise[2] == 0, "R6 single pulse", 32'(rise), 0);
    // R4 unmapped line (entry 10 invalid, channel bits 3)
    wr_reg('h128, 'h03);
    @(negedge clk); req[10] = 1;
    repeat (5) @(negedge clk);
    chk(lvl[3] == 0 && rise == 0, "R4 unmapped ignored", 32'({rise, lvl}), 32'h0004);
    // R8 entry 20 also maps to channel 2, its line low -> channel falls
    wr_reg('h150, 'h82);
    @(negedge clk);
    chk(lvl[2] == 0 && fall[2] == 1, "R8 highest wins / R7 fall", 32'({fall, lvl}), 32'h0400);
    @(negedge clk); req[20] = 1;
    repeat (4) @(negedge clk);
    chk(lvl[2] == 1, "R8 highest line high", 32'(lvl), 32'h04);
    // R9 bad channel 9
    wr_reg('h114, 'h89);
    chk(err == 1, "R9 err set", 32'(err), 1);
    rd_reg('h114, d); chk(d == 8'h89, "R9 stored", 32'(d), 32'h89);
    @(negedge clk); req[5] = 1;
    repeat (5) @(negedge clk);
    chk(lvl == 8'h04, "R9 routes nothing", 32'(lvl), 32'h04);
    // random phase, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) req[$urandom % NREQ] ^= 1'b1;
      if ($urandom % 16 == 0) begin
        int e = $urandom % NREQ;
        int a = (e < 64) ? 'h100 + 4*e : 'h1100 + 4*(e-64);
        wr = 1; addr = 16'(a); wdata = 8'({$urandom % 2, 2'b00, 5'($urandom % 10)});
        @(negedge clk); wr = 0;
      end else if ($urandom % 16 == 0) begin
        rd = 1; addr = 16'('h100 + 4*($urandom % 64));
        @(negedge clk); rd = 0;
      end
    end
    repeat (5) @(negedge clk);
    summary();
  end
endmodule